// File: doc/BRIEF.md
# Serial Potentiometer Wiper Write Controller

This block is the command side of a two-wire serial slave that sets three digital potentiometer wipers. The bus master sends three bytes: a device byte carrying the slave address and a write direction bit, a command byte naming the channel and the kind of write, and a code byte with the new tap. The block acknowledges the bytes it accepts by pulling the data line low through an open-drain enable. It then commits the code to the live wiper register of the selected channel. It can also commit the code to that channel's retained (shadow) register. Both kinds of register are ordinary flops.

A recall input models a supply cycle of the potentiometer domain. It copies every shadow register into its live wiper and abandons any transfer in flight. After a retained write, a busy flag stays high for a fixed programming window, and new device bytes are refused during that window. Codes above a channel's top tap saturate at that tap.

Top module: `wiper_write_ctrl`

## Requirements
- R1: The device byte is acknowledged only when its upper seven bits equal 1010111 and its bit 0 (direction) is 0. Any other device byte gets no acknowledge and changes no register.
- R2: Command byte bits 6:2 must be zero, and bits 1:0 (channel select) must not be 11. Otherwise the command byte is not acknowledged, the following code byte is not acknowledged, and no register changes until the next START.
- R3: A command byte with bit 7 = 0 writes the code to the live wiper only. The selected channel's shadow keeps its value, so a later recall restores the old setting.
- R4: A command byte with bit 7 = 1 writes the code to both the live wiper and the shadow. `write_busy` then rises and stays high for PROG_CYCLES clock cycles.
- R5: Channel 0 saturates at 63, channel 1 at 99 and channel 2 at 255. A larger code sets the top tap and never wraps.
- R6: While `wel` is low, the code byte is still acknowledged but no wiper or shadow changes and `write_busy` stays low.
- R7: The code takes effect on the rising SCL edge of the acknowledge clock that follows bit D0, and not before that edge.
- R8: A STOP or a repeated START before that edge abandons the transfer without writing. A transfer that starts after a repeated START is handled normally.
- R9: A high `recall` loads every live wiper from its shadow and returns the command logic to idle. If a recall arrives in the same cycle as a commit, the recall wins and the write is discarded entirely.
- R10: After reset, every wiper and shadow holds RESET_CODE saturated to its channel, `sda_oe` is low and `write_busy` is low.
- R11: While `write_busy` is high, a matching device byte is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line |
| sda_in | input | 1 | Serial data line as seen on the wire |
| sda_oe | output | 1 | High pulls the data line low (acknowledge) |
| wel | input | 1 | Write enable; commits are suppressed while low |
| recall | input | 1 | Supply-cycle recall of shadow codes into wipers |
| wiper0 | output | 8 | Live tap of channel 0 |
| wiper1 | output | 8 | Live tap of channel 1 |
| wiper2 | output | 8 | Live tap of channel 2 |
| write_busy | output | 1 | High during the retained-write programming window |

## Verification
The commit of a code byte and a recall can land in the same clock cycle. The bench provokes this by raising SCL for the acknowledge clock and asserting `recall` on the same clock edge. Both inputs pass through the same synchronizer depth, so the block sees the SCL rise and the recall in one cycle. The outcome is judged at the ports: every wiper must equal its retained code, `write_busy` must stay low, and a second recall must show that the shadow of the targeted channel kept its old code.

// File: rtl/wwc_pkg.sv
package wwc_pkg;

  localparam int NUM_CH = 3;
  localparam int CODE_W = 8;
  localparam int SEL_W  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_INSTR,
    ST_INSTR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_HOLD
  } cmd_state_e;

  // Highest legal code of each channel
  function automatic logic [CODE_W-1:0] tap_limit(input int ch);
    case (ch)
      0:       tap_limit = CODE_W'(63);
      1:       tap_limit = CODE_W'(99);
      default: tap_limit = CODE_W'(255);
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] saturate(input logic [CODE_W-1:0] code,
                                                 input logic [CODE_W-1:0] lim);
    saturate = (code > lim) ? lim : code;
  endfunction

endpackage

// File: rtl/wwc_line_sampler.sv
module wwc_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic recall_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_bit,
  output logic recall_s
);

  // bit 0 = scl, bit 1 = sda, bit 2 = recall; all share one depth
  localparam logic [2:0] IDLE_LINES = 3'b011;

  logic [SYNC_STAGES-1:0][2:0] chain_q;
  logic [2:0]                  cur;
  logic [1:0]                  prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {SYNC_STAGES{IDLE_LINES}};
    end else begin
      chain_q[0] <= {recall_in, sda_in, scl_in};
      for (int i = 1; i < SYNC_STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign cur = chain_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 2'b11;
    end else begin
      prev_q <= cur[1:0];
    end
  end

  assign scl_rise  = cur[0] & ~prev_q[0];
  assign scl_fall  = ~cur[0] & prev_q[0];
  assign start_det = cur[0] & prev_q[0] & prev_q[1] & ~cur[1];
  assign stop_det  = cur[0] & prev_q[0] & ~prev_q[1] & cur[1];
  assign sda_bit   = cur[1];
  assign recall_s  = cur[2];

endmodule

// File: rtl/wwc_cmd_fsm.sv
module wwc_cmd_fsm
  import wwc_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1010111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_bit,
  input  logic              recall_s,
  input  logic              busy,
  input  logic              wel,
  output logic              sda_oe,
  output logic              commit,
  output logic              commit_nv,
  output logic [SEL_W-1:0]  commit_sel,
  output logic [CODE_W-1:0] commit_code,
  output logic              fsm_idle
);

  localparam logic [3:0] BYTE_BITS = 4'd8;

  cmd_state_e        state_q, state_n;
  logic [CODE_W-1:0] shreg_q, shreg_n;
  logic [3:0]        cnt_q, cnt_n;
  logic              oe_q, oe_n;
  logic              wt_q, wt_n;
  logic [SEL_W-1:0]  sel_q, sel_n;
  logic              byte_end;
  logic              addr_ok;
  logic              instr_ok;

  assign byte_end = scl_fall && (cnt_q == BYTE_BITS);
  assign addr_ok  = (shreg_q[7:1] == DEV_ADDR) && !shreg_q[0] && !busy;
  assign instr_ok = (shreg_q[6:SEL_W] == '0) && (32'(shreg_q[SEL_W-1:0]) < NUM_CH);

  always_comb begin
    state_n = state_q;
    shreg_n = shreg_q;
    cnt_n   = cnt_q;
    oe_n    = oe_q;
    wt_n    = wt_q;
    sel_n   = sel_q;
    if (recall_s || stop_det) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
    end else if (start_det) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      oe_n    = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_INSTR, ST_DATA: begin
          if (scl_rise) begin
            shreg_n = {shreg_q[CODE_W-2:0], sda_bit};
            cnt_n   = cnt_q + 4'd1;
          end else if (byte_end) begin
            cnt_n = '0;
            if (state_q == ST_ADDR) begin
              state_n = addr_ok ? ST_ADDR_ACK : ST_HOLD;
              oe_n    = addr_ok;
            end else if (state_q == ST_INSTR) begin
              state_n = instr_ok ? ST_INSTR_ACK : ST_HOLD;
              oe_n    = instr_ok;
              wt_n    = shreg_q[7];
              sel_n   = shreg_q[SEL_W-1:0];
            end else begin
              state_n = ST_DATA_ACK;
              oe_n    = 1'b1;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            state_n = ST_INSTR;
            oe_n    = 1'b0;
          end
        end
        ST_INSTR_ACK: begin
          if (scl_fall) begin
            state_n = ST_DATA;
            oe_n    = 1'b0;
          end
        end
        ST_DATA_ACK: begin
          if (scl_fall) begin
            state_n = ST_HOLD;
            oe_n    = 1'b0;
          end
        end
        default: begin
          state_n = state_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      wt_q    <= 1'b0;
      sel_q   <= '0;
    end else begin
      state_q <= state_n;
      shreg_q <= shreg_n;
      cnt_q   <= cnt_n;
      oe_q    <= oe_n;
      wt_q    <= wt_n;
      sel_q   <= sel_n;
    end
  end

  // The code is taken on the rising edge of the acknowledge clock
  assign commit      = (state_q == ST_DATA_ACK) && scl_rise && wel && !recall_s;
  assign commit_nv   = wt_q;
  assign commit_sel  = sel_q;
  assign commit_code = shreg_q;
  assign sda_oe      = oe_q;
  assign fsm_idle    = (state_q == ST_IDLE);

endmodule

// File: rtl/wwc_wiper_bank.sv
module wwc_wiper_bank
  import wwc_pkg::*;
#(
  parameter logic [CODE_W-1:0] RESET_CODE = 8'h20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          recall_s,
  input  logic                          commit,
  input  logic                          commit_nv,
  input  logic [SEL_W-1:0]              commit_sel,
  input  logic [CODE_W-1:0]             commit_code,
  output logic [NUM_CH-1:0][CODE_W-1:0] wipers,
  output logic [NUM_CH-1:0][CODE_W-1:0] shadows
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [CODE_W-1:0] LIM      = tap_limit(ch);
    localparam logic [CODE_W-1:0] INIT_VAL = saturate(RESET_CODE, LIM);

    logic [CODE_W-1:0] w_q, w_n, s_q, s_n, code_sat;
    logic              hit;

    always_comb begin
      hit      = commit && (commit_sel == SEL_W'(ch));
      code_sat = saturate(commit_code, LIM);
      w_n      = w_q;
      s_n      = s_q;
      if (recall_s) begin
        w_n = s_q;
      end else if (hit) begin
        w_n = code_sat;
        if (commit_nv) begin
          s_n = code_sat;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        w_q <= INIT_VAL;
        s_q <= INIT_VAL;
      end else begin
        w_q <= w_n;
        s_q <= s_n;
      end
    end

    assign wipers[ch]  = w_q;
    assign shadows[ch] = s_q;
  end

endmodule

// File: rtl/wwc_prog_timer.sv
module wwc_prog_timer #(
  parameter int PROG_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy
);

  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (launch) begin
      cnt_n = CNT_W'(PROG_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/wiper_write_ctrl.sv
module wiper_write_ctrl
  import wwc_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'b1010111,
  parameter logic [CODE_W-1:0] RESET_CODE  = 8'h20,
  parameter int                PROG_CYCLES = 400,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic              wel,
  input  logic              recall,
  output logic [CODE_W-1:0] wiper0,
  output logic [CODE_W-1:0] wiper1,
  output logic [CODE_W-1:0] wiper2,
  output logic              write_busy
);

  logic                          scl_rise, scl_fall, start_det, stop_det;
  logic                          sda_bit, recall_s;
  logic                          commit, commit_nv, fsm_idle;
  logic [SEL_W-1:0]              commit_sel;
  logic [CODE_W-1:0]             commit_code;
  logic [NUM_CH-1:0][CODE_W-1:0] wipers, shadows;

  wwc_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) i_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .recall_in (recall),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_bit   (sda_bit),
    .recall_s  (recall_s)
  );

  wwc_cmd_fsm #(.DEV_ADDR(DEV_ADDR)) i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .sda_bit     (sda_bit),
    .recall_s    (recall_s),
    .busy        (write_busy),
    .wel         (wel),
    .sda_oe      (sda_oe),
    .commit      (commit),
    .commit_nv   (commit_nv),
    .commit_sel  (commit_sel),
    .commit_code (commit_code),
    .fsm_idle    (fsm_idle)
  );

  wwc_wiper_bank #(.RESET_CODE(RESET_CODE)) i_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .recall_s    (recall_s),
    .commit      (commit),
    .commit_nv   (commit_nv),
    .commit_sel  (commit_sel),
    .commit_code (commit_code),
    .wipers      (wipers),
    .shadows     (shadows)
  );

  wwc_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (commit && commit_nv),
    .busy   (write_busy)
  );

  assign wiper0 = wipers[0];
  assign wiper1 = wipers[1];
  assign wiper2 = wipers[2];

endmodule

// File: rtl/wwc_checker.sv
module wwc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [23:0] wbus,
  input logic [23:0] sbus,
  input logic        commit,
  input logic        commit_nv,
  input logic        recall_s,
  input logic        stop_det,
  input logic        fsm_idle,
  input logic        write_busy
);

  // R5: live taps never exceed their channel limit
  p_tap_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wbus[7:0] <= 8'd63) && (wbus[15:8] <= 8'd99));

  // R6: a wiper moves only through a commit or a recall
  p_wiper_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wbus != $past(wbus)) |-> $past(commit || recall_s));

  // R3: a shadow moves only through a retained commit
  p_shadow_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sbus != $past(sbus)) |-> $past(commit && commit_nv));

  // R4: a retained commit opens the programming window
  p_busy_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && commit_nv) |=> write_busy);

  // R8: a STOP returns the command logic to idle
  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> fsm_idle);

  // R9: recall copies the shadows into the wipers
  p_recall_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    recall_s |=> (wbus == $past(sbus)));

endmodule

bind wiper_write_ctrl wwc_checker i_wwc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .wbus       (wipers),
  .sbus       (shadows),
  .commit     (commit),
  .commit_nv  (commit_nv),
  .recall_s   (recall_s),
  .stop_det   (stop_det),
  .fsm_idle   (fsm_idle),
  .write_busy (write_busy)
);

// File: tb/test_wiper_write_ctrl.sv
module test_wiper_write_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;
  localparam logic [7:0] DEV_W = 8'hAE;

  logic clk, rst_n, scl, m_sda, sda_oe, wel, recall, write_busy;
  logic [7:0] wiper0, wiper1, wiper2;
  logic sda_line;
  int   checks, errors;
  logic [7:0] exp_w [3];
  logic [7:0] exp_s [3];

  assign sda_line = m_sda & ~sda_oe;

  wiper_write_ctrl i_wiper_write_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl),
    .sda_in     (sda_line),
    .sda_oe     (sda_oe),
    .wel        (wel),
    .recall     (recall),
    .wiper0     (wiper0),
    .wiper1     (wiper1),
    .wiper2     (wiper2),
    .write_busy (write_busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] wiper_of(input int ch);
    return (ch == 0) ? wiper0 : (ch == 1) ? wiper1 : wiper2;
  endfunction

  task automatic chk_all(input string tag);
    for (int c = 0; c < 3; c++) chk(tag, wiper_of(c), exp_w[c]);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q); scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    ack = ~sda_line;
    wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic write_cmd(input logic [7:0] dev, input logic [7:0] ins,
                           input logic [7:0] dat, output logic [2:0] acks);
    bus_start();
    send_byte(dev, acks[2]);
    send_byte(ins, acks[1]);
    send_byte(dat, acks[0]);
    bus_stop();
  endtask

  task automatic do_recall();
    recall = 1'b1; wq(1); recall = 1'b0; wq(6);
    for (int c = 0; c < 3; c++) exp_w[c] = exp_s[c];
  endtask

  task automatic wait_idle_busy();
    for (int i = 0; i < 2000 && write_busy; i++) wq(1);
  endtask

  task automatic t_reset();
    chk("R10 sda_oe", sda_oe, 0);
    chk("R10 busy", write_busy, 0);
    chk_all("R10 wiper reset");
  endtask

  task automatic t_address();
    logic [2:0] a;
    write_cmd(8'hAC, 8'h01, 8'h05, a);
    chk("R1 other address nack", a[2], 0);
    write_cmd(8'hAF, 8'h01, 8'h05, a);
    chk("R1 read direction nack", a[2], 0);
    chk_all("R1 no change");
  endtask

  task automatic t_volatile();
    logic [2:0] a;
    write_cmd(DEV_W, 8'h01, 8'h40, a);
    chk("R1 acks on valid write", a, 3'b111);
    exp_w[1] = 8'h40;
    chk_all("R3 live wiper written");
    chk("R3 no busy", write_busy, 0);
    do_recall();
    chk_all("R3 shadow kept, R9 recall");
  endtask

  task automatic t_nonvolatile();
    logic [2:0] a;
    write_cmd(DEV_W, 8'h80, 8'h15, a);
    exp_w[0] = 8'h15; exp_s[0] = 8'h15;
    chk_all("R4 retained write");
    chk("R4 busy high", write_busy, 1);
    write_cmd(DEV_W, 8'h02, 8'h33, a);
    chk("R11 nack while busy", a[2], 0);
    chk_all("R11 no change");
    wait_idle_busy();
    chk("R4 busy ends", write_busy, 0);
    do_recall();
    chk_all("R4 shadow recalled");
  endtask

  task automatic t_clamp();
    logic [2:0] a;
    write_cmd(DEV_W, 8'h00, 8'hC8, a); exp_w[0] = 8'h3F;
    chk("R5 ch0 saturates", wiper0, exp_w[0]);
    write_cmd(DEV_W, 8'h01, 8'h64, a); exp_w[1] = 8'h63;
    chk("R5 ch1 100 saturates", wiper1, exp_w[1]);
    write_cmd(DEV_W, 8'h01, 8'h63, a);
    chk("R5 ch1 99 exact", wiper1, 8'h63);
    write_cmd(DEV_W, 8'h02, 8'hFF, a); exp_w[2] = 8'hFF;
    chk("R5 ch2 top", wiper2, exp_w[2]);
    write_cmd(DEV_W, 8'h81, 8'hC8, a); exp_w[1] = 8'h63; exp_s[1] = 8'h63;
    wait_idle_busy();
    do_recall();
    chk_all("R5 retained saturation");
  endtask

  task automatic t_bad_instr();
    logic [2:0] a;
    write_cmd(DEV_W, 8'h04, 8'h01, a);
    chk("R2 nonzero field nack", a, 3'b100);
    write_cmd(DEV_W, 8'h03, 8'h01, a);
    chk("R2 reserved select nack", a, 3'b100);
    chk_all("R2 no change");
  endtask

  task automatic t_wel();
    logic [2:0] a;
    wel = 1'b0;
    write_cmd(DEV_W, 8'h02, 8'h11, a);
    chk("R6 code acked", a, 3'b111);
    write_cmd(DEV_W, 8'h82, 8'h11, a);
    chk("R6 no busy", write_busy, 0);
    chk_all("R6 no change");
    wel = 1'b1;
  endtask

  task automatic t_abort();
    logic a;
    bus_start(); send_byte(DEV_W, a); send_byte(8'h02, a);
    send_bits(8'h11, 4);
    bus_stop();
    chk_all("R8 stop mid code");
    bus_start(); send_byte(DEV_W, a); send_byte(8'h82, a);
    bus_start(); send_byte(DEV_W, a); send_byte(8'h00, a); send_byte(8'h2A, a);
    bus_stop();
    exp_w[0] = 8'h2A;
    chk("R8 restart then write", a, 1);
    chk_all("R8 first transfer dropped");
    chk("R8 no retained write", write_busy, 0);
  endtask

  task automatic t_timing();
    logic a;
    bus_start(); send_byte(DEV_W, a); send_byte(8'h02, a);
    send_bits(8'h5A, 8);
    m_sda = 1'b1; wq(Q);
    chk("R7 unchanged before edge", wiper2, exp_w[2]);
    scl = 1'b1; wq(Q);
    exp_w[2] = 8'h5A;
    chk("R7 taken on ack edge", wiper2, exp_w[2]);
    wq(Q); scl = 1'b0; wq(Q);
    bus_stop();
  endtask

  task automatic t_coincide();
    logic a;
    bus_start(); send_byte(DEV_W, a); send_byte(8'h82, a);
    send_bits(8'h77, 8);
    m_sda = 1'b1; wq(Q);
    scl = 1'b1; recall = 1'b1; wq(1); recall = 1'b0;
    wq(2*Q); scl = 1'b0; wq(Q);
    bus_stop();
    for (int c = 0; c < 3; c++) exp_w[c] = exp_s[c];
    chk_all("R9 recall wins");
    chk("R9 no busy", write_busy, 0);
    do_recall();
    chk("R9 shadow untouched", wiper2, exp_s[2]);
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; wel = 1'b1; recall = 1'b0;
    for (int c = 0; c < 3; c++) begin exp_w[c] = 8'h20; exp_s[c] = 8'h20; end
    wq(5); rst_n = 1'b1; wq(5);
    t_reset();
    t_address();
    t_volatile();
    t_nonvolatile();
    t_clamp();
    t_bad_instr();
    t_wel();
    t_abort();
    t_timing();
    t_coincide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule